// File: doc/BRIEF.md
# Path Signal Label Monitor

This block checks the path signal label byte, which arrives once per received frame, and keeps three defect flags for it. The unequipped flag reports a path that carries the all-zero label. The mismatch flag reports that the label accepted from the line differs from the label software expects. The unstable flag reports a label that keeps changing and never settles.

A received label is accepted into a readable register only after it has persisted for five frames in a row. The unequipped flag is suppressed when software expects the all-zero label. While the path is unequipped, the mismatch flag is forced low.

Upstream logic presents the byte together with a one-cycle frame strobe. Software writes the expected label through a write strobe. A configuration bit sets the settling count for the unstable flag to either three or five frames.

Top module: `c2_label_mon`

## Requirements
- R1: A synchronous reset sets these values: unequipped flag 0, unstable flag 0, accepted label 0x00 and expected label 0x01. Because 0x00 differs from 0x01, the mismatch flag resets to 1.
- R2: The accepted label takes a received value only once that value has arrived in 5 consecutive strobed frames. After 4 such frames it keeps its previous contents.
- R3: With a nonzero expected label, the unequipped flag rises on the 5th consecutive strobed frame that carries 0x00, and not before.
- R4: A raised unequipped flag falls on the 5th consecutive strobed frame that carries a nonzero value, and not before.
- R5: While the expected label is 0x00, the unequipped flag stays 0 whatever labels arrive.
- R6: Outside the unequipped state, the mismatch flag is 1 when the accepted label differs from the expected label and 0 when they are equal. It follows a write to the expected label on the clock edge that takes the write.
- R7: While the unequipped flag is 1, the mismatch flag is 0, even if the accepted and expected labels differ.
- R8: The unstable flag falls on the frame on which one value completes its run of N consecutive frames. N is 3 when `persist_sel` is 0 and 5 when it is 1.
- R9: The unstable flag rises on the 8th consecutive strobed frame on which no value has reached its run of N.
- R10: Cycles with the frame strobe low change no flag, counter or label, whatever the byte input carries. Every result due to a frame appears on the clock edge that samples the strobe.

Each port is listed below in the order of the port list.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frm_vld | input | 1 | One-cycle strobe marking the frame's label byte |
| c2_in | input | 8 | Received path signal label byte |
| exp_wr | input | 1 | Write strobe for the expected label |
| exp_wdata | input | 8 | Expected label write data |
| persist_sel | input | 1 | Settling count for the unstable flag: 0 means 3 frames, 1 means 5 frames |
| exp_label | output | 8 | Current expected label |
| acc_label | output | 8 | Last accepted (persisted) label |
| uneq_flag | output | 1 | Unequipped defect |
| plm_flag | output | 1 | Label mismatch defect |
| unstab_flag | output | 1 | Label unstable defect |

## Verification
All results are registered once. Every frame-driven output is due on the first rising edge after the strobe is driven, and a write to the expected label shows on `exp_label` and `plm_flag` after one edge as well. The bench drives each input at a falling edge and samples at the next falling edge, half a period after the edge that must update the result. Before each threshold frame it checks the value one frame early, so an off-by-one in any count shows as a failure. Idle cycles that carry a changing byte with the strobe low are placed between frames, and the bench checks afterwards that nothing has moved.

// File: rtl/c2lm_pkg.sv
package c2lm_pkg;
  typedef enum logic {
    PERSIST_SHORT = 1'b0,
    PERSIST_LONG  = 1'b1
  } persist_e;
endpackage

// File: rtl/c2lm_run_tracker.sv
module c2lm_run_tracker #(
  parameter int LBL_W   = 8,
  parameter int ACC_CNT = 5,
  parameter int RUN_MAX = 5,
  localparam int RUN_W  = $clog2(RUN_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frm_vld,
  input  logic [LBL_W-1:0] c2_in,
  output logic [RUN_W-1:0] run_nxt,
  output logic [LBL_W-1:0] acc_nxt,
  output logic [LBL_W-1:0] acc_label
);
  logic [LBL_W-1:0] last_q;
  logic [RUN_W-1:0] run_q;

  always_comb begin
    if (c2_in != last_q)               run_nxt = RUN_W'(1);
    else if (run_q == RUN_W'(RUN_MAX)) run_nxt = run_q;
    else                               run_nxt = run_q + RUN_W'(1);
    acc_nxt = (frm_vld && run_nxt >= RUN_W'(ACC_CNT)) ? c2_in : acc_label;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      last_q    <= '0;
      run_q     <= '0;
      acc_label <= '0;
    end else begin
      if (frm_vld) begin
        last_q <= c2_in;
        run_q  <= run_nxt;
      end
      acc_label <= acc_nxt;
    end
  end

  a_r10_acc_idle: assert property (@(posedge clk) disable iff (rst)
    !$past(frm_vld) |-> $stable(acc_label));
  a_r2_acc_persisted: assert property (@(posedge clk) disable iff (rst)
    (acc_label != $past(acc_label)) |-> (acc_label == $past(c2_in)));
endmodule

// File: rtl/c2lm_uneq_det.sv
module c2lm_uneq_det #(
  parameter int LBL_W    = 8,
  parameter int UNEQ_CNT = 5,
  localparam int CNT_W   = $clog2(UNEQ_CNT + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frm_vld,
  input  logic [LBL_W-1:0] c2_in,
  input  logic             exp_zero,
  output logic             uneq_nxt,
  output logic             uneq_q
);
  logic [CNT_W-1:0] zrun_q, nzrun_q, zrun_nxt, nzrun_nxt;
  logic             is_zero;

  assign is_zero = (c2_in == '0);

  always_comb begin
    zrun_nxt  = zrun_q;
    nzrun_nxt = nzrun_q;
    uneq_nxt  = uneq_q;
    if (frm_vld) begin
      if (is_zero) begin
        nzrun_nxt = '0;
        zrun_nxt  = (zrun_q == CNT_W'(UNEQ_CNT)) ? zrun_q : zrun_q + CNT_W'(1);
      end else begin
        zrun_nxt  = '0;
        nzrun_nxt = (nzrun_q == CNT_W'(UNEQ_CNT)) ? nzrun_q : nzrun_q + CNT_W'(1);
      end
      if (zrun_nxt == CNT_W'(UNEQ_CNT))       uneq_nxt = 1'b1;
      else if (nzrun_nxt == CNT_W'(UNEQ_CNT)) uneq_nxt = 1'b0;
    end
    if (exp_zero) uneq_nxt = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      zrun_q  <= '0;
      nzrun_q <= '0;
      uneq_q  <= 1'b0;
    end else begin
      zrun_q  <= zrun_nxt;
      nzrun_q <= nzrun_nxt;
      uneq_q  <= uneq_nxt;
    end
  end

  a_r3_rise_on_zero: assert property (@(posedge clk) disable iff (rst)
    $rose(uneq_q) |-> ($past(frm_vld) && $past(is_zero)));
  a_r4_fall_cause: assert property (@(posedge clk) disable iff (rst)
    $fell(uneq_q) |-> ($past(exp_zero) || ($past(frm_vld) && !$past(is_zero))));
endmodule

// File: rtl/c2lm_unstab_det.sv
module c2lm_unstab_det
  import c2lm_pkg::*;
#(
  parameter int SHORT_CNT = 3,
  parameter int LONG_CNT  = 5,
  parameter int RUN_MAX   = 5,
  parameter int WIN_LEN   = 8,
  localparam int RUN_W    = $clog2(RUN_MAX + 1),
  localparam int WIN_W    = $clog2(WIN_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frm_vld,
  input  logic [RUN_W-1:0] run_nxt,
  input  logic             persist_sel,
  output logic             unstab_q
);
  logic [WIN_W-1:0] win_q;
  logic [RUN_W-1:0] need;
  persist_e         mode;

  assign mode = persist_e'(persist_sel);
  assign need = (mode == PERSIST_LONG) ? RUN_W'(LONG_CNT) : RUN_W'(SHORT_CNT);

  always_ff @(posedge clk) begin
    if (rst) begin
      win_q    <= '0;
      unstab_q <= 1'b0;
    end else if (frm_vld) begin
      if (run_nxt >= need) begin
        win_q    <= '0;
        unstab_q <= 1'b0;
      end else if (win_q != WIN_W'(WIN_LEN)) begin
        win_q <= win_q + WIN_W'(1);
        if (win_q == WIN_W'(WIN_LEN - 1)) unstab_q <= 1'b1;
      end
    end
  end

  a_r10_unstab_idle: assert property (@(posedge clk) disable iff (rst)
    !$past(frm_vld) |-> $stable(unstab_q));
  a_r9_rise_window: assert property (@(posedge clk) disable iff (rst)
    $rose(unstab_q) |-> (win_q == WIN_W'(WIN_LEN)));
endmodule

// File: rtl/c2_label_mon.sv
module c2_label_mon #(
  parameter int LBL_W     = 8,
  parameter int ACC_CNT   = 5,
  parameter int UNEQ_CNT  = 5,
  parameter int SHORT_CNT = 3,
  parameter int LONG_CNT  = 5,
  parameter int WIN_LEN   = 8,
  parameter logic [LBL_W-1:0] EXP_RST = 8'h01,
  localparam int RUN_MAX  = (ACC_CNT > LONG_CNT) ? ACC_CNT : LONG_CNT,
  localparam int RUN_W    = $clog2(RUN_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frm_vld,
  input  logic [LBL_W-1:0] c2_in,
  input  logic             exp_wr,
  input  logic [LBL_W-1:0] exp_wdata,
  input  logic             persist_sel,
  output logic [LBL_W-1:0] exp_label,
  output logic [LBL_W-1:0] acc_label,
  output logic             uneq_flag,
  output logic             plm_flag,
  output logic             unstab_flag
);
  logic [LBL_W-1:0] exp_nxt, acc_nxt;
  logic [RUN_W-1:0] run_nxt;
  logic             uneq_nxt;

  assign exp_nxt = exp_wr ? exp_wdata : exp_label;

  always_ff @(posedge clk) begin
    if (rst) begin
      exp_label <= EXP_RST;
      plm_flag  <= (EXP_RST != '0);
    end else begin
      exp_label <= exp_nxt;
      plm_flag  <= (acc_nxt != exp_nxt) && !uneq_nxt;
    end
  end

  c2lm_run_tracker #(.LBL_W(LBL_W), .ACC_CNT(ACC_CNT), .RUN_MAX(RUN_MAX)) u_run (
    .clk(clk), .rst(rst), .frm_vld(frm_vld), .c2_in(c2_in),
    .run_nxt(run_nxt), .acc_nxt(acc_nxt), .acc_label(acc_label));

  c2lm_uneq_det #(.LBL_W(LBL_W), .UNEQ_CNT(UNEQ_CNT)) u_uneq (
    .clk(clk), .rst(rst), .frm_vld(frm_vld), .c2_in(c2_in),
    .exp_zero(exp_label == '0), .uneq_nxt(uneq_nxt), .uneq_q(uneq_flag));

  c2lm_unstab_det #(.SHORT_CNT(SHORT_CNT), .LONG_CNT(LONG_CNT), .RUN_MAX(RUN_MAX),
                    .WIN_LEN(WIN_LEN)) u_unstab (
    .clk(clk), .rst(rst), .frm_vld(frm_vld), .run_nxt(run_nxt),
    .persist_sel(persist_sel), .unstab_q(unstab_flag));

  a_r7_uneq_masks_plm: assert property (@(posedge clk) disable iff (rst)
    uneq_flag |-> !plm_flag);
  a_r5_exp_zero_no_uneq: assert property (@(posedge clk) disable iff (rst)
    (exp_label == '0) |=> !uneq_flag);
  a_r6_plm_on_write: assert property (@(posedge clk) disable iff (rst)
    (exp_wr && !frm_vld && !uneq_flag && (exp_wdata == acc_label)) |=> !plm_flag);
endmodule

// File: tb/c2_label_mon_bench.sv
module c2_label_mon_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       frm_vld = 1'b0;
  logic [7:0] c2_in = 8'h00;
  logic       exp_wr = 1'b0;
  logic [7:0] exp_wdata = 8'h00;
  logic       persist_sel = 1'b0;
  logic [7:0] exp_label, acc_label;
  logic       uneq_flag, plm_flag, unstab_flag;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  c2_label_mon u_c2_label_mon (
    .clk(clk), .rst(rst), .frm_vld(frm_vld), .c2_in(c2_in),
    .exp_wr(exp_wr), .exp_wdata(exp_wdata), .persist_sel(persist_sel),
    .exp_label(exp_label), .acc_label(acc_label), .uneq_flag(uneq_flag),
    .plm_flag(plm_flag), .unstab_flag(unstab_flag));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic frame(input logic [7:0] v);
    @(negedge clk); frm_vld = 1'b1; c2_in = v;
    @(negedge clk); frm_vld = 1'b0; c2_in = ~v;
  endtask

  task automatic frames(input logic [7:0] v, input int n);
    for (int i = 0; i < n; i++) frame(v);
  endtask

  task automatic write_exp(input logic [7:0] v);
    @(negedge clk); exp_wr = 1'b1; exp_wdata = v;
    @(negedge clk); exp_wr = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 uneq", uneq_flag, 0);
    chk("R1 plm", plm_flag, 1);
    chk("R1 unstab", unstab_flag, 0);
    chk("R1 acc", acc_label, 8'h00);
    chk("R1 exp", exp_label, 8'h01);
  endtask

  task automatic t_accept;
    frames(8'h01, 4);
    chk("R2 acc after 4", acc_label, 8'h00);
    chk("R6 plm before accept", plm_flag, 1);
    frame(8'h01);
    chk("R2 acc after 5", acc_label, 8'h01);
    chk("R6 plm match", plm_flag, 0);
  endtask

  task automatic t_uneq;
    frames(8'h00, 4);
    chk("R3 uneq after 4", uneq_flag, 0);
    frame(8'h00);
    chk("R3 uneq after 5", uneq_flag, 1);
    chk("R7 plm masked", plm_flag, 0);
    frames(8'h02, 4);
    chk("R4 uneq after 4 nonzero", uneq_flag, 1);
    frame(8'h02);
    chk("R4 uneq after 5 nonzero", uneq_flag, 0);
    chk("R6 plm mismatch", plm_flag, 1);
    write_exp(8'h02);
    chk("R6 plm after write", plm_flag, 0);
  endtask

  task automatic t_suppress;
    write_exp(8'h00);
    frames(8'h00, 6);
    chk("R5 uneq suppressed", uneq_flag, 0);
    chk("R5 acc", acc_label, 8'h00);
    write_exp(8'h01);
    frames(8'h05, 5);
    chk("R6 plm 05 vs 01", plm_flag, 1);
  endtask

  task automatic t_unstable;
    persist_sel = 1'b0;
    for (int i = 0; i < 7; i++) frame(8'h10 + 8'(i));
    chk("R9 unstab after 7", unstab_flag, 0);
    frame(8'h17);
    chk("R9 unstab after 8", unstab_flag, 1);
    frames(8'h20, 2);
    chk("R8 short after 2", unstab_flag, 1);
    frame(8'h20);
    chk("R8 short after 3", unstab_flag, 0);
    persist_sel = 1'b1;
    for (int i = 0; i < 8; i++) frame(8'h40 + 8'(i));
    chk("R9 unstab long mode", unstab_flag, 1);
    frames(8'h30, 4);
    chk("R8 long after 4", unstab_flag, 1);
    frame(8'h30);
    chk("R8 long after 5", unstab_flag, 0);
  endtask

  task automatic t_idle;
    frames(8'h50, 4);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); c2_in = 8'h90 + 8'(i);
    end
    chk("R10 acc idle", acc_label, 8'h30);
    chk("R10 unstab idle", unstab_flag, 0);
    frame(8'h50);
    chk("R10 run kept across idle", acc_label, 8'h50);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset;
    t_accept;
    t_uneq;
    t_suppress;
    t_unstable;
    t_idle;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule